// File: doc/BRIEF.md
# GPIO Pin Controller with Edge Interrupts

This block controls thirteen general-purpose pins through a byte-wide register bus with 16-bit addresses. Each pin owns two registers. The output control register sets the pin's direction, its drive type (open drain or push-pull), whether a pull resistor is enabled and which pull is selected, and the value the pin drives. The input control register reports the synchronised pad level and selects which edges of that level raise an interrupt pulse. The pins form three banks: pins 0-6, pins 7-10 and pins 11-12. Bank membership has no effect on the behaviour of this block.

The controller sends per-pin output value, output enable, open-drain flag and pull controls to the pad models as encoded signals. Analog pad behaviour and resistor strength are outside this block. Pad inputs pass through a two-flop synchroniser. A third flop holds the previous synchronised level, and each pin has its own edge-pulse output for an interrupt aggregator. A write takes effect on the clock edge where the write enable is high. Read data is combinational from the address.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After synchronous active-low reset, every register holds zero. As a result, on every pin `pad_oe`=0, `pad_od`=1, `pad_pull_en`=0, `pad_pull_sel`=00 and `edge_pulse`=0.
- R2: The output control register of pin p sits at 0x4E44+p. The input control register of pin p sits at 0x4E51+p, for p = 0..12. A written output control byte reads back at its address.
- R3: Output control field positions are: bit 5 direction (1 = output), bit 4 drive type (1 = push-pull, 0 = open drain), bit 3 pull enable, bits 2:1 pull select (00 2k down, 01 2k up, 10 50k down, 11 50k up), bit 0 output value. The pin's `pad_out` equals bit 0. `pad_od` is the inverse of bit 4. `pad_pull_en` equals bit 3. `pad_pull_sel` equals bits 2:1. `pad_oe` is 0 whenever bit 5 is 0.
- R4: With direction = output, push-pull mode gives `pad_oe`=1. Open-drain mode gives `pad_oe`=1 only when the output value is 0, so the pin is driven low. With an output value of 1 in open-drain mode, the pad floats.
- R5: Bit 0 of the input control register reads the pad level after a two-flop synchroniser. The level is visible after the second rising clock edge following a pad change.
- R6: Bits 2:1 of the input control register select the edge mode: 00 none, 01 falling, 10 rising, 11 both. An enabled change of the synchronised level raises `edge_pulse` for exactly one cycle. The pulse is high in the same cycle that the new level becomes readable. A change in a direction that is not enabled raises no pulse.
- R7: Output control bits 7:6 and input control bits 7:3 read as zero and ignore writes. Input control bit 0 is read-only: a write to it does not change the reported level.
- R8: A write to any address outside 0x4E44..0x4E5D changes no register and no pad output. A read of such an address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Register byte address |
| bus_we | input | 1 | Write enable, registers on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pad_in | input | 13 | Asynchronous pad levels, one bit per pin |
| pad_out | output | 13 | Value to drive, one bit per pin |
| pad_oe | output | 13 | Output enable, one bit per pin |
| pad_od | output | 13 | Open-drain flag, one bit per pin |
| pad_pull_en | output | 13 | Pull resistor enable, one bit per pin |
| pad_pull_sel | output | 26 | Pull selection, two bits per pin (pin p at [2p+1:2p]) |
| edge_pulse | output | 13 | One-cycle edge-detect pulse, one bit per pin |

## Verification
A register write lands on the first rising edge while `bus_we` is high. Read data and pad controls are then valid at the following falling edge, so the bench checks them there. A pad change driven at a falling edge becomes readable, and raises its edge pulse, after two rising edges. The bench therefore samples the pulse two falling edges after the change. It samples again one falling edge later to confirm that the pulse has dropped. Before and after ignored writes, the bench reads each affected register and the pad vectors at the same falling-edge position. It then compares the two sets of values.

// File: rtl/gpio_edge_ctrl_pkg.sv
// Package: shared types for the GPIO edge controller.
// Holds the output-control field layout and the edge-mode encoding, which
// the pin cell and the top-level read path both decode.
package gpio_edge_ctrl_pkg;

    // Output control register, low six bits, in bit order 5..0.
    typedef struct packed {
        logic       dir;        // bit 5: 1 = output
        logic       push_pull;  // bit 4: 1 = push-pull, 0 = open drain
        logic       pull_en;    // bit 3
        logic [1:0] pull_sel;   // bits 2:1
        logic       val;        // bit 0: output value
    } ocr_t;

    localparam int unsigned OCR_W = $bits(ocr_t);

    // Interrupt detect field of the input control register (bits 2:1).
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_RISE = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_mode_e;

endpackage

// File: rtl/gpio_sync2.sv
// Module: gpio_sync2
// Two-flop synchroniser for a vector of asynchronous pad levels.
// Assumes every bit is an independent level. No bus coherence is implied.
module gpio_sync2 #(
    parameter int unsigned WIDTH = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;

    // Purpose: move the pad levels into the clock domain through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_pin_cell.sv
// Module: gpio_pin_cell
// One pin's control state: the output control register, the edge-mode
// field and the previous-level flop used for edge detection.
// Assumes `lvl` is already synchronised to clk.
module gpio_pin_cell
    import gpio_edge_ctrl_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_ocr,
    input  logic         wr_icr,
    input  logic [5:0]   wdata,
    input  logic         lvl,
    output ocr_t         ocr_q,
    output edge_mode_e   mode_q,
    output logic         pad_out,
    output logic         pad_oe,
    output logic         pad_od,
    output logic         pad_pull_en,
    output logic [1:0]   pad_pull_sel,
    output logic         edge_pulse
);
    logic lvl_prev_q;
    logic rise, fall;

    // Purpose: output control register; reserved bits are never stored.
    always_ff @(posedge clk) begin
        if (!rst_n)      ocr_q <= '0;
        else if (wr_ocr) ocr_q <= ocr_t'(wdata);
    end

    // Purpose: edge-mode field; bit 0 of the input register is not stored.
    always_ff @(posedge clk) begin
        if (!rst_n)      mode_q <= EDGE_OFF;
        else if (wr_icr) mode_q <= edge_mode_e'(wdata[2:1]);
    end

    // Purpose: remember last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_prev_q <= 1'b0;
        else        lvl_prev_q <= lvl;
    end

    assign rise = lvl & ~lvl_prev_q;
    assign fall = ~lvl & lvl_prev_q;

    // Purpose: select enabled edge directions.
    always_comb begin
        edge_pulse = 1'b0;
        if (rise && (mode_q == EDGE_RISE || mode_q == EDGE_ANY)) edge_pulse = 1'b1;
        if (fall && (mode_q == EDGE_FALL || mode_q == EDGE_ANY)) edge_pulse = 1'b1;
    end

    assign pad_out      = ocr_q.val;
    assign pad_od       = ~ocr_q.push_pull;
    assign pad_pull_en  = ocr_q.pull_en;
    assign pad_pull_sel = ocr_q.pull_sel;
    // Open drain floats a logic one; push-pull drives both levels.
    assign pad_oe       = ocr_q.dir & (ocr_q.push_pull | ~ocr_q.val);

    // R6: a pulse only appears with an enabled mode.
    p_pulse_needs_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        edge_pulse |-> (mode_q != EDGE_OFF));

    // R3: no drive while the pin is an input.
    p_oe_needs_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe |-> ocr_q.dir);

    // R4: an open-drain output drives exactly when the value is low.
    p_od_drive_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ocr_q.dir && pad_od) |-> (pad_oe == !pad_out));

    // R6: a pulse always follows a level change.
    p_pulse_on_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        edge_pulse |-> (lvl != lvl_prev_q));
endmodule

// File: rtl/gpio_edge_ctrl.sv
// Module: gpio_edge_ctrl (top)
// Register-mapped controller for NUM_PINS general-purpose pins.
// Decodes the byte bus, builds one pin cell per pin and returns read data
// combinationally. Assumes one access per cycle and that bus_addr is stable
// while bus_we is high.
module gpio_edge_ctrl
    import gpio_edge_ctrl_pkg::*;
#(
    parameter int unsigned NUM_PINS = 13,
    parameter logic [15:0] OCR_BASE = 16'h4E44,
    parameter logic [15:0] ICR_BASE = 16'h4E51
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [15:0]           bus_addr,
    input  logic                  bus_we,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [NUM_PINS-1:0]   pad_od,
    output logic [NUM_PINS-1:0]   pad_pull_en,
    output logic [2*NUM_PINS-1:0] pad_pull_sel,
    output logic [NUM_PINS-1:0]   edge_pulse
);
    localparam int unsigned STATE_W = NUM_PINS * (OCR_W + 2);

    logic [NUM_PINS-1:0] lvl_s;
    logic [NUM_PINS-1:0] hit_ocr, hit_icr;
    ocr_t                ocr_q  [NUM_PINS];
    edge_mode_e          mode_q [NUM_PINS];
    logic [STATE_W-1:0]  state_flat;
    logic                any_hit;
    logic                unused_wbits;

    assign unused_wbits = &{1'b0, bus_wdata[7:6]};

    gpio_sync2 #(.WIDTH(NUM_PINS)) sync_i (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(lvl_s)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign hit_ocr[p] = (bus_addr == OCR_BASE + 16'(p));
        assign hit_icr[p] = (bus_addr == ICR_BASE + 16'(p));
        assign state_flat[p*(OCR_W+2) +: OCR_W+2] = {ocr_q[p], mode_q[p]};

        gpio_pin_cell cell_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_ocr       (bus_we & hit_ocr[p]),
            .wr_icr       (bus_we & hit_icr[p]),
            .wdata        (bus_wdata[5:0]),
            .lvl          (lvl_s[p]),
            .ocr_q        (ocr_q[p]),
            .mode_q       (mode_q[p]),
            .pad_out      (pad_out[p]),
            .pad_oe       (pad_oe[p]),
            .pad_od       (pad_od[p]),
            .pad_pull_en  (pad_pull_en[p]),
            .pad_pull_sel (pad_pull_sel[2*p +: 2]),
            .edge_pulse   (edge_pulse[p])
        );
    end

    assign any_hit = |{hit_ocr, hit_icr};

    // Purpose: combinational read mux; unmapped addresses return zero.
    always_comb begin
        bus_rdata = 8'h00;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (hit_ocr[p]) bus_rdata = {2'b00, ocr_q[p]};
            if (hit_icr[p]) bus_rdata = {5'b00000, mode_q[p], lvl_s[p]};
        end
    end

    // R8: an unmapped write leaves all pin state untouched.
    p_oob_write_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !any_hit) |=> $stable(state_flat));

    // R7: reserved input-control bits read as zero.
    p_icr_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_icr) |-> (bus_rdata[7:3] == 5'b0));

    // R7: reserved output-control bits read as zero.
    p_ocr_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_ocr) |-> (bus_rdata[7:6] == 2'b0));

    // R8: unmapped reads return zero.
    p_oob_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !any_hit |-> (bus_rdata == 8'h00));
endmodule

// File: tb/gpio_edge_ctrl_tb_top.sv
// Bench for gpio_edge_ctrl: a table of output-control vectors walked by one
// loop, then directed tests for reset, level read, edges and unmapped access.
module gpio_edge_ctrl_tb_top;
    localparam int N = 13;
    localparam logic [15:0] OB = 16'h4E44;
    localparam logic [15:0] IB = 16'h4E51;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out, pad_oe, pad_od, pad_pull_en, edge_pulse;
    logic [2*N-1:0] pad_pull_sel;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    gpio_edge_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od),
        .pad_pull_en(pad_pull_en), .pad_pull_sel(pad_pull_sel),
        .edge_pulse(edge_pulse)
    );

    // Vector: {pin[3:0], byte[7:0], oe, out, od, pull_en, pull_sel[1:0]}
    localparam logic [17:0] VEC [8] = '{
        {4'd0,  8'h1A, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01},
        {4'd1,  8'h3B, 1'b1, 1'b1, 1'b0, 1'b1, 2'b01},
        {4'd6,  8'h3A, 1'b1, 1'b0, 1'b0, 1'b1, 2'b01},
        {4'd7,  8'h21, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00},
        {4'd10, 8'h20, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00},
        {4'd11, 8'h0E, 1'b0, 1'b0, 1'b1, 1'b1, 2'b11},
        {4'd12, 8'h34, 1'b1, 1'b0, 1'b0, 1'b0, 2'b10},
        {4'd5,  8'hC1, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Change one pad at a falling edge, check the pulse two falling edges later
    // and its absence one edge after that, then the readable level.
    task automatic edge_case(input int pin, input logic lvl, input logic exp_pulse, input string req);
        logic [7:0] r;
        @(negedge clk);
        pad_in[pin] = lvl;
        @(negedge clk);
        @(negedge clk);
        check(req, edge_pulse, exp_pulse ? (13'd1 << pin) : 13'd0);
        @(negedge clk);
        check({req, " one cycle"}, edge_pulse, 13'd0);
        rd(IB + 16'(pin), r);
        check("R5 level", r[0], lvl);
    endtask

    initial begin
        logic [7:0] r;
        logic [N-1:0] oe_snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 oe", pad_oe, '0);
        check("R1 od", pad_od, {N{1'b1}});
        check("R1 pull_en", pad_pull_en, '0);
        check("R1 pull_sel", pad_pull_sel, '0);
        check("R1 edge", edge_pulse, '0);
        rd(OB + 16'd4, r); check("R1 ocr", r, 8'h00);
        rd(IB + 16'd9, r); check("R1 icr", r, 8'h00);

        // R2 R3 R4 R7: table walk
        for (int i = 0; i < 8; i++) begin
            int p;
            p = int'(VEC[i][17:14]);
            wr(OB + 16'(p), VEC[i][13:6]);
            check("R3/R4 oe", pad_oe[p], VEC[i][5]);
            check("R3 out", pad_out[p], VEC[i][4]);
            check("R3 od", pad_od[p], VEC[i][3]);
            check("R3 pull_en", pad_pull_en[p], VEC[i][2]);
            check("R3 pull_sel", pad_pull_sel[2*p +: 2], VEC[i][1:0]);
            rd(OB + 16'(p), r);
            check("R2/R7 ocr readback", r, {2'b00, VEC[i][11:6]});
        end

        // R7: input control reserved bits and read-only bit 0
        wr(IB + 16'd3, 8'hF9);
        rd(IB + 16'd3, r); check("R7 icr mask", r, 8'h00);
        wr(IB + 16'd3, 8'hFF);
        rd(IB + 16'd3, r); check("R7 icr bit0 ro", r, 8'h06);

        // R5 R6: edge modes on pin 3 (01 fall, 10 rise, 11 both, 00 none)
        wr(IB + 16'd3, 8'h04);
        edge_case(3, 1'b1, 1'b1, "R6 rise mode rise");
        edge_case(3, 1'b0, 1'b0, "R6 rise mode fall");
        wr(IB + 16'd3, 8'h02);
        edge_case(3, 1'b1, 1'b0, "R6 fall mode rise");
        edge_case(3, 1'b0, 1'b1, "R6 fall mode fall");
        wr(IB + 16'd12, 8'h06);
        edge_case(12, 1'b1, 1'b1, "R6 both mode rise");
        edge_case(12, 1'b0, 1'b1, "R6 both mode fall");
        wr(IB + 16'd12, 8'h00);
        edge_case(12, 1'b1, 1'b0, "R6 off mode rise");
        rd(IB + 16'd12, r); check("R5 icr with high level", r, 8'h01);

        // R8: unmapped writes and reads
        oe_snap = pad_oe;
        wr(16'h4E43, 8'hFF);
        wr(16'h4E5E, 8'hFF);
        wr(16'h0044, 8'h3F);
        check("R8 oe held", pad_oe, oe_snap);
        rd(OB, r);            check("R8 pin0 ocr held", r, 8'h1A);
        rd(OB + 16'd12, r);   check("R8 pin12 ocr held", r, 8'h34);
        rd(IB, r);            check("R8 pin0 icr held", r, 8'h00);
        rd(16'h4E43, r);      check("R8 read below", r, 8'h00);
        rd(16'h4E5E, r);      check("R8 read above", r, 8'h00);

        // R1: reset in mid-run clears programmed registers
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        rd(OB + 16'd1, r); check("R1 re-reset ocr", r, 8'h00);
        check("R1 re-reset oe", pad_oe, '0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule